// File: doc/BRIEF.md
# Burst-Mode DMA Channel Sequencer

This block drives one DMA channel that copies data between two memory-mapped locations in burst fashion. Each unit transfer reads one byte or one word from a source address and then writes it to a destination address. Units follow each other back-to-back, with the bus held the whole time, until the transfer counter reaches zero. The last unit is followed by one idle dead state before the bus is given back. The channel is loaded through a plain load strobe and started by setting its enable bit.

A non-maskable interrupt clears the enable bit. A running burst then stops at the next unit boundary: the unit in flight always finishes first. Once the final unit's read has begun, that unit, its dead state and the completion pulse all still happen. A suspended burst keeps its count and its current addresses, so setting the enable bit again resumes it. A pending request from a higher-priority channel is granted only while this channel is idle, never in the middle of a burst.

Every bus cycle is a valid/ready exchange. The sequencer raises `mem_valid` with the address, direction, size and (for writes) data. It holds all of them unchanged until a cycle in which `mem_ready` is high, which completes the cycle at that clock edge. A low `mem_ready` is back-pressure and can last any number of cycles. `bus_req` and `bus_gnt` are plain level signals.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, `bus_req`, `mem_valid`, `ch_enable`, `done`, `aborted` and `hp_gnt` are all 0.
- R2: When the channel is idle with enable set, a non-zero count and `hp_req` low, `bus_req` rises on the next clock. No bus cycle (`mem_valid`) starts until `bus_gnt` is seen high.
- R3: Each unit is a read (`mem_we`=0) at the source address, then a write (`mem_we`=1) at the destination address. The write data equals the data returned by the read. While `mem_valid` is high and `mem_ready` is low, the address, `mem_we` and the data stay stable.
- R4: After a non-final write completes, the next unit's read starts on the following cycle, and `bus_req` stays high for the whole burst.
- R5: `mem_word`=1 selects word size and 0 selects byte size. After every completed write, both addresses advance by 2 (word) or 1 (byte), and the count drops by one.
- R6: The write that takes the count to zero is followed by exactly one dead cycle, with `bus_req`=1 and `mem_valid`=0. Then `bus_req` falls, `done` is high for exactly one cycle (the first idle cycle), and `ch_enable` is cleared.
- R7: `hp_gnt` follows `hp_req` only while the channel is idle, and is 0 whenever `bus_req` is high. A high `hp_req` in idle keeps the channel from starting.
- R8: `nmi` clears `ch_enable` on the next clock. It wins over an `en_set` in the same cycle. `en_set` alone sets `ch_enable`.
- R9: An `nmi` during a non-final unit lets that unit finish, then releases the bus on the next cycle with no dead cycle. It sets `aborted` and gives no `done`. `aborted` is cleared by `en_set` or by an accepted load.
- R10: An `nmi` that arrives after the final unit's read has begun does not stop it: the dead cycle and `done` follow, and `aborted` stays 0.
- R11: A suspended burst keeps its remaining count and addresses. After `en_set`, it continues at the next addresses, and the total number of writes equals the loaded count.
- R12: `cfg_load` is accepted only while `bus_req` is low, and is ignored during a burst. A loaded count of zero never starts a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load strobe for addresses, count and size |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Number of unit transfers |
| cfg_word | input | 1 | 1 = word units, 0 = byte units |
| en_set | input | 1 | Sets the enable bit |
| nmi | input | 1 | Non-maskable interrupt; clears the enable bit |
| hp_req | input | 1 | Request pending from a higher-priority channel |
| hp_gnt | output | 1 | Bus handed to the higher-priority channel |
| bus_req | output | 1 | Bus request, held from first read to release |
| bus_gnt | input | 1 | Bus grant |
| mem_valid | output | 1 | Bus cycle valid |
| mem_ready | input | 1 | Bus cycle completes this clock |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_word | output | 1 | Size of the current cycle |
| mem_addr | output | AW | Cycle address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, captured when a read completes |
| ch_enable | output | 1 | Current enable bit |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Burst was suspended by an NMI |

## Verification
`bus_req` rises one clock after the enable, count and `hp_req` conditions hold. A read cycle appears one clock after the grant is seen. Each write appears one clock after its read completes, and the next read, or the dead cycle, appears one clock after the write completes. `done` and the bus release come one clock after the dead cycle, and `ch_enable` drops one clock after `nmi`. A behavioural reference in the bench is stepped on every rising edge from the same inputs. Its predicted outputs are compared with the design's outputs two time units after every falling edge. At that point every register has settled, and inputs changed at the falling edge have propagated through `hp_gnt`. The directed checks on write addresses, `done` and bus-release counts are sampled the same way, so each one lands in the cycle its requirement names.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DEAD  = 3'd4
  } seq_state_t;

  localparam int unsigned NUM_PTRS = 2;
  localparam int unsigned PTR_SRC  = 0;
  localparam int unsigned PTR_DST  = 1;

endpackage

// File: rtl/dma_ptr_reg.sv
module dma_ptr_reg #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic          word,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] step;

  always_comb begin
    step = word ? AW'(2) : AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (adv) begin
      ptr <= ptr + step;
    end
  end

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          is_zero,
  output logic          is_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_comb begin
    is_zero = (cnt == '0);
    is_last = (cnt == CW'(1));
  end

  a_r5_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !is_zero) |=> (cnt == $past(cnt) - CW'(1)))
    else $error("a_r5_count_drops");

endmodule

// File: rtl/dma_burst_fsm.sv
module dma_burst_fsm
  import dma_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic       en_set,
  input  logic       nmi,
  input  logic       hp_req,
  input  logic       bus_gnt,
  input  logic       mem_ready,
  input  logic       cnt_zero,
  input  logic       cnt_last,
  output seq_state_t state,
  output logic       load_ok,
  output logic       rd_fire,
  output logic       wr_fire,
  output logic       ch_enable,
  output logic       done,
  output logic       aborted
);

  seq_state_t nxt;
  logic       stop_evt;
  logic       final_evt;

  always_comb begin
    rd_fire   = (state == ST_READ)  && mem_ready;
    wr_fire   = (state == ST_WRITE) && mem_ready;
    final_evt = wr_fire && cnt_last;
    stop_evt  = wr_fire && !cnt_last && (!ch_enable || nmi);
    load_ok   = cfg_load && (state == ST_IDLE);
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (ch_enable && !cnt_zero && !hp_req) nxt = ST_REQ;
      ST_REQ: begin
        if (!ch_enable)   nxt = ST_IDLE;
        else if (bus_gnt) nxt = ST_READ;
      end
      ST_READ:  if (mem_ready) nxt = ST_WRITE;
      ST_WRITE: begin
        if (final_evt)     nxt = ST_DEAD;
        else if (stop_evt) nxt = ST_IDLE;
        else if (wr_fire)  nxt = ST_READ;
      end
      ST_DEAD:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ch_enable <= 1'b0;
      done      <= 1'b0;
      aborted   <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_DEAD);
      if (nmi)                    ch_enable <= 1'b0;
      else if (en_set)            ch_enable <= 1'b1;
      else if (state == ST_DEAD)  ch_enable <= 1'b0;
      if (stop_evt)               aborted <= 1'b1;
      else if (en_set || load_ok) aborted <= 1'b0;
    end
  end

  a_r8_nmi_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !ch_enable)
    else $error("a_r8_nmi_clears_enable");

  a_r6_dead_then_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEAD) |=> (state == ST_IDLE) && done && !ch_enable)
    else $error("a_r6_dead_then_release");

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("a_r6_done_single");

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && aborted)
    else $error("a_r9_stop_releases");

  a_r10_final_completes: assert property (@(posedge clk) disable iff (!rst_n)
    final_evt |=> (state == ST_DEAD))
    else $error("a_r10_final_completes");

  a_r4_next_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !cnt_last && ch_enable && !nmi) |=> (state == ST_READ))
    else $error("a_r4_next_unit");

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_burst_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_word,
  input  logic          en_set,
  input  logic          nmi,
  input  logic          hp_req,
  output logic          hp_gnt,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic          mem_word,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          ch_enable,
  output logic          done,
  output logic          aborted
);

  seq_state_t    state;
  logic          load_ok, rd_fire, wr_fire;
  logic          cnt_zero, cnt_last;
  logic [CW-1:0] cnt;
  logic          size_word;
  logic [DW-1:0] data_buf;
  logic [AW-1:0] ptr_q   [NUM_PTRS];
  logic [AW-1:0] ptr_init[NUM_PTRS];

  always_comb begin
    ptr_init[PTR_SRC] = cfg_src;
    ptr_init[PTR_DST] = cfg_dst;
  end

  dma_burst_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .en_set    (en_set),
    .nmi       (nmi),
    .hp_req    (hp_req),
    .bus_gnt   (bus_gnt),
    .mem_ready (mem_ready),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .state     (state),
    .load_ok   (load_ok),
    .rd_fire   (rd_fire),
    .wr_fire   (wr_fire),
    .ch_enable (ch_enable),
    .done      (done),
    .aborted   (aborted)
  );

  dma_count_unit #(.CW(CW)) i_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ok),
    .load_val (cfg_count),
    .dec      (wr_fire),
    .cnt      (cnt),
    .is_zero  (cnt_zero),
    .is_last  (cnt_last)
  );

  for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
    dma_ptr_reg #(.AW(AW)) i_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_ok),
      .load_val (ptr_init[g]),
      .adv      (wr_fire),
      .word     (size_word),
      .ptr      (ptr_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_word <= 1'b0;
      data_buf  <= '0;
    end else begin
      if (load_ok) size_word <= cfg_word;
      if (rd_fire) data_buf  <= mem_rdata;
    end
  end

  always_comb begin
    bus_req   = (state != ST_IDLE);
    mem_valid = (state == ST_READ) || (state == ST_WRITE);
    mem_we    = (state == ST_WRITE);
    mem_word  = size_word;
    mem_addr  = mem_we ? ptr_q[PTR_DST] : ptr_q[PTR_SRC];
    mem_wdata = data_buf;
    hp_gnt    = hp_req && (state == ST_IDLE);
  end

  a_r3_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata))
    else $error("a_r3_hold_cycle");

  a_r7_hp_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !hp_gnt)
    else $error("a_r7_hp_blocked");

  a_r2_no_cycle_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !mem_valid)
    else $error("a_r2_no_cycle_on_request");

  a_r12_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && bus_req && !wr_fire) |=> $stable(cnt))
    else $error("a_r12_load_ignored");

  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && mem_ready) |=> (mem_valid && mem_we))
    else $error("a_r3_write_follows_read");

endmodule

// File: tb/test_dma_burst_seq.sv
module test_dma_burst_seq;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [AW-1:0] cfg_src = '0;
  logic [AW-1:0] cfg_dst = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          cfg_word = 1'b0;
  logic          en_set = 1'b0;
  logic          nmi = 1'b0;
  logic          hp_req = 1'b0;
  logic          hp_gnt;
  logic          bus_req;
  logic          bus_gnt = 1'b1;
  logic          mem_valid;
  logic          mem_ready = 1'b1;
  logic          mem_we;
  logic          mem_word;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          ch_enable;
  logic          done;
  logic          aborted;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  int rcyc = 0;
  int wdog = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem_addr ^ 16'h5AC3;

  dma_burst_seq #(.AW(AW), .DW(DW), .CW(CW)) i_dma_burst_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_count(cfg_count), .cfg_word(cfg_word),
    .en_set(en_set), .nmi(nmi), .hp_req(hp_req), .hp_gnt(hp_gnt),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ch_enable(ch_enable), .done(done), .aborted(aborted)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 request, 2 read, 3 write, 4 dead
  int       m_ph = 0;
  bit       m_en = 0, m_done = 0, m_abort = 0, m_word = 0;
  int       m_src = 0, m_dst = 0, m_cnt = 0, m_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_en = 0; m_done = 0; m_abort = 0; m_word = 0;
      m_src = 0; m_dst = 0; m_cnt = 0; m_data = 0;
    end else begin
      int  nph;
      bit  stop, accept;
      nph = m_ph; stop = 0;
      accept = cfg_load && (m_ph == 0);
      m_done = (m_ph == 4);
      case (m_ph)
        0: if (m_en && m_cnt != 0 && !hp_req) nph = 1;
        1: if (!m_en) nph = 0; else if (bus_gnt) nph = 2;
        2: if (mem_ready) begin m_data = (m_src ^ 'h5AC3) & 'hFFFF; nph = 3; end
        3: if (mem_ready) begin
             if (m_cnt == 1) nph = 4;
             else if (!m_en || nmi) begin nph = 0; stop = 1; end
             else nph = 2;
             m_src = (m_src + (m_word ? 2 : 1)) & 'hFFFF;
             m_dst = (m_dst + (m_word ? 2 : 1)) & 'hFFFF;
             m_cnt = m_cnt - 1;
           end
        default: nph = 0;
      endcase
      if (nmi) m_en = 0;
      else if (en_set) m_en = 1;
      else if (m_ph == 4) m_en = 0;
      if (stop) m_abort = 1;
      else if (en_set || accept) m_abort = 0;
      if (accept) begin
        m_src = int'(cfg_src); m_dst = int'(cfg_dst);
        m_cnt = int'(cfg_count); m_word = cfg_word;
      end
      m_ph = nph;
    end
  end

  // Observation two time units after each falling edge
  logic [AW-1:0] wr_q[$];
  int done_cnt = 0, fall_cnt = 0;
  bit prev_req = 0;

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R2 bus_req", 32'(bus_req), 32'(m_ph != 0));
      chk("R3 mem_valid", 32'(mem_valid), 32'(m_ph == 2 || m_ph == 3));
      if (m_ph == 2 || m_ph == 3) begin
        chk("R3 mem_we", 32'(mem_we), 32'(m_ph == 3));
        chk("R5 mem_addr", 32'(mem_addr), (m_ph == 3) ? m_dst : m_src);
        chk("R5 mem_word", 32'(mem_word), 32'(m_word));
      end
      if (m_ph == 3) chk("R3 mem_wdata", 32'(mem_wdata), m_data);
      chk("R7 hp_gnt", 32'(hp_gnt), 32'(hp_req && m_ph == 0));
      chk("R8 ch_enable", 32'(ch_enable), 32'(m_en));
      chk("R6 done", 32'(done), 32'(m_done));
      chk("R9 aborted", 32'(aborted), 32'(m_abort));
      if (mem_valid && mem_ready && mem_we) wr_q.push_back(mem_addr);
      if (done) done_cnt++;
      if (prev_req && !bus_req) fall_cnt++;
      prev_req = bus_req;
    end
  end

  always @(negedge clk) begin
    #1;
    rcyc++;
    mem_ready = (ready_mode == 0) ? 1'b1 : ((rcyc % 3) == 0);
  end

  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", wdog);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_obs();
    wr_q.delete(); done_cnt = 0; fall_cnt = 0;
  endtask

  task automatic do_load(input int src, input int dst, input int cnt, input bit word);
    step(1);
    cfg_src = AW'(src); cfg_dst = AW'(dst); cfg_count = CW'(cnt); cfg_word = word;
    cfg_load = 1'b1;
    step(1);
    cfg_load = 1'b0;
  endtask

  task automatic pulse_en();
    en_set = 1'b1; step(1); en_set = 1'b0;
  endtask

  task automatic pulse_nmi();
    nmi = 1'b1; step(1); nmi = 1'b0;
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    step(3);
    while (bus_req && k < 2000) begin step(1); k++; end
    step(2);
  endtask

  task automatic wait_read_after(input int nwr);
    int k;
    k = 0;
    while (!(wr_q.size() == nwr && mem_valid && !mem_we) && k < 2000) begin
      step(1); k++;
    end
  endtask

  task automatic chk_addrs(input string tag, input int base, input int stride, input int n);
    chk({tag, " write count"}, 32'(wr_q.size()), 32'(n));
    for (int i = 0; i < n && i < wr_q.size(); i++)
      chk({tag, " write addr"}, 32'(wr_q[i]), 32'(base + stride * i));
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 mem_valid", 32'(mem_valid), 0);
    chk("R1 ch_enable", 32'(ch_enable), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 aborted", 32'(aborted), 0);
    chk("R1 hp_gnt", 32'(hp_gnt), 0);

    // Byte burst, no back-pressure: R4, R5, R6
    clear_obs();
    do_load('h100, 'h200, 3, 0);
    pulse_en();
    wait_idle();
    chk_addrs("R5 byte", 'h200, 1, 3);
    chk("R6 done pulses", 32'(done_cnt), 1);
    chk("R4 single release", 32'(fall_cnt), 1);
    chk("R6 enable cleared", 32'(ch_enable), 0);

    // Word burst with back-pressure and late grant: R2, R3, R5
    clear_obs();
    ready_mode = 1;
    bus_gnt = 1'b0;
    do_load('h300, 'h400, 4, 1);
    pulse_en();
    step(4);
    chk("R2 request held", 32'(bus_req), 1);
    chk("R2 no cycle before grant", 32'(mem_valid), 0);
    bus_gnt = 1'b1;
    wait_idle();
    chk_addrs("R5 word", 'h400, 2, 4);
    chk("R4 single release word", 32'(fall_cnt), 1);

    // Higher-priority request: R7
    clear_obs();
    ready_mode = 0;
    hp_req = 1'b1;
    do_load('h10, 'h20, 4, 0);
    pulse_en();
    step(4);
    chk("R7 start deferred", 32'(bus_req), 0);
    chk("R7 hp granted idle", 32'(hp_gnt), 1);
    hp_req = 1'b0;
    step(3);
    hp_req = 1'b1;
    step(1);
    chk("R7 hp blocked in burst", 32'(hp_gnt), 0);
    wait_idle();
    chk("R7 hp granted after", 32'(hp_gnt), 1);
    chk_addrs("R7 burst", 'h20, 1, 4);
    hp_req = 1'b0;

    // NMI mid burst then resume: R8, R9, R11
    clear_obs();
    ready_mode = 1;
    do_load('h40, 'h80, 5, 0);
    pulse_en();
    wait_read_after(2);
    pulse_nmi();
    chk("R8 enable cleared by nmi", 32'(ch_enable), 0);
    wait_idle();
    chk("R9 aborted set", 32'(aborted), 1);
    chk("R9 unit finished", 32'(wr_q.size()), 3);
    chk("R9 no done", 32'(done_cnt), 0);
    pulse_en();
    chk("R9 aborted cleared", 32'(aborted), 0);
    wait_idle();
    chk_addrs("R11 resumed", 'h80, 1, 5);
    chk("R11 done once", 32'(done_cnt), 1);

    // NMI during final unit: R10
    clear_obs();
    do_load('h500, 'h600, 2, 1);
    pulse_en();
    wait_read_after(1);
    pulse_nmi();
    wait_idle();
    chk("R10 done", 32'(done_cnt), 1);
    chk("R10 not aborted", 32'(aborted), 0);
    chk_addrs("R10 final", 'h600, 2, 2);

    // Load during burst ignored, zero count: R12; en_set vs nmi: R8
    clear_obs();
    ready_mode = 0;
    do_load('h700, 'h800, 3, 0);
    pulse_en();
    step(2);
    cfg_src = 'h900; cfg_dst = 'hA00; cfg_count = 9; cfg_word = 1;
    cfg_load = 1'b1;
    step(1);
    cfg_load = 1'b0;
    wait_idle();
    chk_addrs("R12 load ignored", 'h800, 1, 3);
    clear_obs();
    do_load('h0, 'h0, 0, 0);
    pulse_en();
    step(5);
    chk("R12 zero count idle", 32'(bus_req), 0);
    chk("R12 zero count writes", 32'(wr_q.size()), 0);
    en_set = 1'b1; nmi = 1'b1;
    step(1);
    en_set = 1'b0; nmi = 1'b0;
    chk("R8 nmi wins", 32'(ch_enable), 0);
    step(3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule